// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address byte that opens an I2C transfer is meant for this device while it acts as a slave. After a start or repeated start, the first received byte is compared with three candidates: a programmable 7-bit own address, the SMBus ARP address (7-bit value 110_0001b), and the general call address (byte 00h). The ARP and general call candidates each have their own enable bit. When that bit is clear, the address is treated as an unrecognised one.

The bit-level receiver supplies the byte with a one-cycle valid strobe and marks each start condition. The matcher returns a held match flag with a 2-bit type code, a one-cycle new-match pulse that a status register can latch, and the read/write direction bit taken from the address byte. Later bytes of the same transfer never change the result.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match`, `match_type`, `new_match` and `rd_wr` are all 0.
- R2: An address byte whose bits 7:1 equal `own_addr` gives `match`=1 and `match_type`=01 in the cycle after `byte_vld`.
- R3: On any match, `rd_wr` takes bit 0 of the matched byte. With no match it is 0.
- R4: The byte 00h gives `match_type`=11 only when `gc_en` is 1. With `gc_en`=0 it gives no match and no pulse.
- R5: A byte whose bits 7:1 equal 110_0001b gives `match_type`=10 only when `arp_en` is 1. With `arp_en`=0 it gives no match and no pulse.
- R6: When more than one candidate fits, the own address wins, then ARP, then general call. Type code 00 means no match.
- R7: Only the first `byte_vld` after `start_det` is evaluated. Later bytes neither pulse `new_match` nor change `match`, `match_type` or `rd_wr`.
- R8: With `slave_mode`=0, a byte produces no match. `match`, `match_type` and `rd_wr` clear in the cycle after `slave_mode` is seen low.
- R9: `start_det` clears `match`, `match_type` and `rd_wr` in the next cycle and re-arms evaluation. A `byte_vld` in the same cycle as `start_det` is ignored.
- R10: `new_match` is high for exactly one cycle per successful match, in the same cycle that `match` first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | Start or repeated start seen (one-cycle) |
| byte_vld | input | 1 | `rx_byte` holds a complete byte (one-cycle) |
| rx_byte | input | 8 | Received byte, bit 0 is the direction bit |
| slave_mode | input | 1 | Controller currently operates as slave |
| gc_en | input | 1 | Enable general call matching |
| arp_en | input | 1 | Enable ARP address matching |
| own_addr | input | 7 | Programmable own 7-bit address |
| match | output | 1 | Current transfer is addressed to this device |
| match_type | output | 2 | 00 none, 01 own, 10 ARP, 11 general call |
| new_match | output | 1 | One-cycle pulse on each new match |
| rd_wr | output | 1 | Direction bit of the matched address byte |

## Verification
The own address is driven with both direction bits. The general call and ARP bytes are each driven with the enable set and with it cleared, which shows that an enable gates only its own candidate. Collision patterns, where the own address equals the ARP address or is zero, show the priority order. Sequences of a non-matching first byte followed by a matching one, a byte sent outside slave mode, and a byte that coincides with a start show that only the first byte after a start is evaluated, and only while in slave mode.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int AW = 7,
  parameter logic [AW-1:0] ARP_ADDR = 7'h61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          byte_vld,
  input  logic [7:0]    rx_byte,
  input  logic          slave_mode,
  input  logic          gc_en,
  input  logic          arp_en,
  input  logic [AW-1:0] own_addr,
  output logic          match,
  output logic [1:0]    match_type,
  output logic          new_match,
  output logic          rd_wr
);

  localparam logic [1:0] T_NONE = 2'b00;
  localparam logic [1:0] T_OWN  = 2'b01;
  localparam logic [1:0] T_ARP  = 2'b10;
  localparam logic [1:0] T_GC   = 2'b11;

  logic       armed;
  logic [1:0] hit;

  wire own_hit = rx_byte[7:8-AW] == own_addr;
  wire arp_hit = arp_en && (rx_byte[7:8-AW] == ARP_ADDR);
  wire gc_hit  = gc_en && (rx_byte == 8'h00);

  assign hit = own_hit ? T_OWN : arp_hit ? T_ARP : gc_hit ? T_GC : T_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      match      <= 1'b0;
      match_type <= T_NONE;
      new_match  <= 1'b0;
      rd_wr      <= 1'b0;
    end else begin
      new_match <= 1'b0;
      if (start_det) begin
        armed      <= 1'b1;
        match      <= 1'b0;
        match_type <= T_NONE;
        rd_wr      <= 1'b0;
      end else if (byte_vld && armed) begin
        armed <= 1'b0;
        if (slave_mode && hit != T_NONE) begin
          match      <= 1'b1;
          match_type <= hit;
          new_match  <= 1'b1;
          rd_wr      <= rx_byte[0];
        end
      end
      if (!slave_mode) begin
        match      <= 1'b0;
        match_type <= T_NONE;
        rd_wr      <= 1'b0;
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    new_match |=> !new_match);
  a_r10_pulse_with_match: assert property (@(posedge clk) disable iff (!rst_n)
    new_match |-> match && match_type != T_NONE);
  a_r8_no_match_outside_slave: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |=> !new_match && !match);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !match && !new_match && match_type == T_NONE);
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    match && !start_det && slave_mode |=> match && $stable(match_type) && $stable(rd_wr));
  a_r4_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) && match_type == T_GC |-> $past(gc_en));
  a_r5_arp_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) && match_type == T_ARP |-> $past(arp_en));

endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 1'b0, byte_vld = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic slave_mode = 1'b1, gc_en = 1'b0, arp_en = 1'b0;
  logic [6:0] own_addr = 7'h3A;
  logic match, new_match, rd_wr;
  logic [1:0] match_type;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
    .rx_byte(rx_byte), .slave_mode(slave_mode), .gc_en(gc_en), .arp_en(arp_en),
    .own_addr(own_addr), .match(match), .match_type(match_type),
    .new_match(new_match), .rd_wr(rd_wr));

  // packed view: {match, match_type, new_match, rd_wr}
  task automatic check(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {match, match_type, new_match, rd_wr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic t_reset();
    check(5'b0_00_0_0, "R1");
  endtask

  task automatic t_own();
    do_start(); send({7'h3A, 1'b1});
    check(5'b1_01_1_1, "R2/R3 own read");
    @(negedge clk); check(5'b1_01_0_1, "R10 pulse ends");
    do_start(); check(5'b0_00_0_0, "R9 start clears");
    send({7'h3A, 1'b0});
    check(5'b1_01_1_0, "R3 own write");
  endtask

  task automatic t_gc();
    gc_en = 1'b1; do_start(); send(8'h00);
    check(5'b1_11_1_0, "R4 gc enabled");
    gc_en = 1'b0; do_start(); send(8'h00);
    check(5'b0_00_0_0, "R4 gc disabled");
  endtask

  task automatic t_arp();
    arp_en = 1'b1; do_start(); send(8'hC3);
    check(5'b1_10_1_1, "R5 arp enabled");
    arp_en = 1'b0; do_start(); send(8'hC3);
    check(5'b0_00_0_0, "R5 arp disabled");
  endtask

  task automatic t_prio();
    arp_en = 1'b1; gc_en = 1'b1;
    own_addr = 7'h61; do_start(); send(8'hC2);
    check(5'b1_01_1_0, "R6 own over arp");
    own_addr = 7'h00; do_start(); send(8'h00);
    check(5'b1_01_1_0, "R6 own over gc");
    own_addr = 7'h3A; do_start(); send(8'h00);
    check(5'b1_11_1_0, "R6 gc when own differs");
    arp_en = 1'b0; gc_en = 1'b0;
  endtask

  task automatic t_first_only();
    do_start(); send(8'h10);
    check(5'b0_00_0_0, "R7 first miss");
    send({7'h3A, 1'b1});
    check(5'b0_00_0_0, "R7 later byte ignored");
    do_start(); send({7'h3A, 1'b0});
    send({7'h3A, 1'b1});
    check(5'b1_01_0_0, "R7 match held on later byte");
  endtask

  task automatic t_mode();
    slave_mode = 1'b0; do_start(); send({7'h3A, 1'b1});
    check(5'b0_00_0_0, "R8 not slave");
    slave_mode = 1'b1; do_start(); send({7'h3A, 1'b1});
    check(5'b1_01_1_1, "R8 slave again");
    @(negedge clk); slave_mode = 1'b0;
    @(negedge clk); check(5'b0_00_0_0, "R8 leaving slave clears");
    slave_mode = 1'b1;
  endtask

  task automatic t_start_collide();
    @(negedge clk); start_det = 1'b1; byte_vld = 1'b1; rx_byte = {7'h3A, 1'b1};
    @(negedge clk); start_det = 1'b0; byte_vld = 1'b0;
    check(5'b0_00_0_0, "R9 byte with start ignored");
    send({7'h3A, 1'b1});
    check(5'b1_01_1_1, "R9 rearmed after start");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); t_reset();
    t_own();
    t_gc();
    t_arp();
    t_prio();
    t_first_only();
    t_mode();
    t_start_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule